// File: doc/BRIEF.md
# Compare/Capture Timer-Counter

This block is a word-addressed timer/counter with four compare/capture channels. In timer mode it advances on a prescaled tick. The block clock is taken as the 16 MHz base, and the tick is that clock divided by 2^p. In counter mode it advances by one on each count task. At run time, a width field gives the counter a wrap length of 8, 16, 24 or 32 bits.

Each channel holds a compare value and a sticky match flag. A capture task copies the live counter into that channel's compare value. On a match, per-channel shortcut bits can zero the counter or halt the timer. A single level interrupt stays high while any flag whose enable is set is pending.

All access goes through one write strobe with a word address and data. A combinational read data bus returns the register that the current address selects. Word addresses are decimal:

| Word | Name | Effect or field |
|------|------|-----------------|
| 0 | start | task |
| 1 | stop | task |
| 2 | count | task |
| 3 | clear | task |
| 4 | shutdown | task |
| 8+i | capture i | task |
| 16+i | match flag i | event register |
| 32 | shortcuts | clear on bits 3:0, stop on bits 11:8 |
| 33 | enable set | see R7 |
| 34 | enable clear | see R7 |
| 40 | mode | bit 0: 0 timer, 1 counter |
| 41 | width | bits 1:0 |
| 42 | prescale | bits 3:0 |
| 48+i | compare i | 32-bit value |

Top module: `cc_timer`

## Requirements
- R1: After reset all registers read 0, the interrupt is low and the timer is stopped.
- R2: The width field encodes 0 as 16 bits, 1 as 8 bits, 2 as 24 bits and 3 as 32 bits. The counter wraps to 0 after 2^width−1.
- R3: In timer mode (mode=0), a start task runs the counter. Counting begins with the edge that accepts the start. The counter advances on every 2^p-th edge, where p is the prescale value, and the last advance lands on the edge that accepts a stop. A start task has no effect in counter mode, and a count task has no effect in timer mode. A prescale write above 9 stores 9.
- R4: A counting step whose new value equals compare i sets match flag i. Only a write of 0 to word 16+i clears the flag, and a write of any other value leaves it unchanged.
- R5: When shortcut bit i (bits 3:0) is set and channel i matches, the counter becomes 0 in that same step.
- R6: When shortcut bit 8+i is set and channel i matches, the timer stops with the matching value held.
- R7: Interrupt enable i sits at bit 16+i. A write to word 33 ORs the written bits in, a write to word 34 clears them, and a read of either word returns the enable mask.
- R8: The interrupt is high exactly while some channel has both its match flag and its enable set.
- R9: Capture task i loads the current counter value into compare i.
- R10: A compare write stores the value modulo 2^width. The clear task zeroes the counter. The stop and shutdown tasks halt the timer.
- R11: A task acts only when written with the value 1. Reads of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, also the 16 MHz tick base |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Write strobe, one access per cycle |
| addr_i | input | 6 | Word address for the write and for the read mux |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench wraps the counter at the 8-bit and 16-bit widths and stops timer runs at exact prescaled tick counts. A design that skipped the wrap, or that counted ticks one edge early or late, would capture a wrong value. It makes the clear shortcut fold the counter back at the match value and lets the stop shortcut freeze it there. A design that applied either shortcut one step late, or compared the old counter value, would show a residue that is off by one. It also writes non-zero values to an event register, writes values other than 1 to task registers, writes oversize compare values and writes an out-of-range prescale. It checks that flags survive, that counters do not move and that stored values are reduced. The interrupt and every read are compared against a behavioural model on every cycle.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int CH_N         = 4;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 6;
    localparam int PRE_W        = 4;
    localparam int PRE_MAX      = 9;
    localparam int DIV_W        = PRE_MAX;
    localparam int SH_STOP_LSB  = 8;
    localparam int IEN_LSB      = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_START  = 6'd0;
    localparam addr_t A_STOP   = 6'd1;
    localparam addr_t A_COUNT  = 6'd2;
    localparam addr_t A_CLEAR  = 6'd3;
    localparam addr_t A_SHUT   = 6'd4;
    localparam addr_t A_CAP    = 6'd8;
    localparam addr_t A_EVT    = 6'd16;
    localparam addr_t A_SHORTS = 6'd32;
    localparam addr_t A_INTSET = 6'd33;
    localparam addr_t A_INTCLR = 6'd34;
    localparam addr_t A_MODE   = 6'd40;
    localparam addr_t A_WIDTH  = 6'd41;
    localparam addr_t A_PRE    = 6'd42;
    localparam addr_t A_CC     = 6'd48;

    typedef enum logic {
        MODE_TIMER   = 1'b0,
        MODE_COUNTER = 1'b1
    } mode_e;

    typedef struct packed {
        logic [DATA_W-1:0]             cnt;
        logic                          run;
        mode_e                         mode;
        logic [1:0]                    width;
        logic [PRE_W-1:0]              pre;
        logic [DIV_W-1:0]              div;
        logic [CH_N-1:0]               evt;
        logic [CH_N-1:0]               en;
        logic [CH_N-1:0]               sh_clr;
        logic [CH_N-1:0]               sh_stop;
        logic [CH_N-1:0][DATA_W-1:0]   cc;
    } state_t;

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] w);
        case (w)
            2'd0:    width_mask = DATA_W'(32'h0000_FFFF);
            2'd1:    width_mask = DATA_W'(32'h0000_00FF);
            2'd2:    width_mask = DATA_W'(32'h00FF_FFFF);
            default: width_mask = '1;
        endcase
    endfunction
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler
    import cct_pkg::*;
(
    input  logic [DIV_W-1:0] div_q,
    input  logic [PRE_W-1:0] pre,
    input  logic             en,
    input  logic             restart,
    output logic             tick,
    output logic [DIV_W-1:0] div_d
);
    logic [DIV_W-1:0] low;

    // bit g of the divider takes part in the tick when g is below the prescale
    for (genvar g = 0; g < DIV_W; g++) begin : g_low
        assign low[g] = (PRE_W'(g) < pre);
    end

    assign tick = en && ((div_q & low) == low);

    always_comb begin
        if (restart)  div_d = '0;
        else if (en)  div_d = div_q + 1'b1;
        else          div_d = div_q;
    end
endmodule

// File: rtl/cct_compare.sv
module cct_compare
    import cct_pkg::*;
(
    input  logic                          adv,
    input  logic [DATA_W-1:0]             nxt,
    input  logic [CH_N-1:0][DATA_W-1:0]   cc,
    input  logic [CH_N-1:0]               sh_clr,
    input  logic [CH_N-1:0]               sh_stop,
    output logic [CH_N-1:0]               hit,
    output logic                          do_clr,
    output logic                          do_stop
);
    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        assign hit[g] = adv && (nxt == cc[g]);
    end

    assign do_clr  = |(hit & sh_clr);
    assign do_stop = |(hit & sh_stop);
endmodule

// File: rtl/cct_readmux.sv
module cct_readmux
    import cct_pkg::*;
(
    input  addr_t                         addr,
    input  logic [CH_N-1:0]               evt,
    input  logic [CH_N-1:0]               en,
    input  logic [CH_N-1:0]               sh_clr,
    input  logic [CH_N-1:0]               sh_stop,
    input  mode_e                         mode,
    input  logic [1:0]                    width,
    input  logic [PRE_W-1:0]              pre,
    input  logic [CH_N-1:0][DATA_W-1:0]   cc,
    output logic [DATA_W-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (addr == A_SHORTS) begin
            rdata[CH_N-1:0]                  = sh_clr;
            rdata[SH_STOP_LSB +: CH_N]       = sh_stop;
        end
        if (addr == A_INTSET || addr == A_INTCLR) begin
            rdata[IEN_LSB +: CH_N] = en;
        end
        if (addr == A_MODE)  rdata[0]         = mode;
        if (addr == A_WIDTH) rdata[1:0]       = width;
        if (addr == A_PRE)   rdata[PRE_W-1:0] = pre;
        for (int i = 0; i < CH_N; i++) begin
            if (addr == A_EVT + addr_t'(i)) rdata[0] = evt[i];
            if (addr == A_CC + addr_t'(i))  rdata    = cc[i];
        end
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cct_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [5:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);
    state_t s_d, s_q;

    logic                  trig;
    logic                  t_start, t_stop, t_count, t_clear, t_shut;
    logic [CH_N-1:0]       t_cap;
    logic                  timer_on, tick, adv, do_clr, do_stop;
    logic [DIV_W-1:0]      div_d;
    logic [CH_N-1:0]       hit;
    logic [DATA_W-1:0]     wmask, nxt;

    // task strobes fire only for the value 1
    assign trig    = (wdata_i == DATA_W'(1));
    assign t_start = wr_i && trig && (addr_i == A_START);
    assign t_stop  = wr_i && trig && (addr_i == A_STOP);
    assign t_count = wr_i && trig && (addr_i == A_COUNT);
    assign t_clear = wr_i && trig && (addr_i == A_CLEAR);
    assign t_shut  = wr_i && trig && (addr_i == A_SHUT);

    for (genvar g = 0; g < CH_N; g++) begin : g_cap
        assign t_cap[g] = wr_i && trig && (addr_i == A_CAP + addr_t'(g));
    end

    assign wmask    = width_mask(s_q.width);
    assign nxt      = (s_q.cnt + 1'b1) & wmask;
    assign timer_on = (s_q.mode == MODE_TIMER) && s_q.run;
    assign adv      = !t_clear &&
                      (((s_q.mode == MODE_COUNTER) && t_count) || (timer_on && tick));

    cct_prescaler u_pre (
        .div_q   (s_q.div),
        .pre     (s_q.pre),
        .en      (timer_on),
        .restart (t_clear || (t_start && s_q.mode == MODE_TIMER)),
        .tick    (tick),
        .div_d   (div_d)
    );

    cct_compare u_cmp (
        .adv     (adv),
        .nxt     (nxt),
        .cc      (s_q.cc),
        .sh_clr  (s_q.sh_clr),
        .sh_stop (s_q.sh_stop),
        .hit     (hit),
        .do_clr  (do_clr),
        .do_stop (do_stop)
    );

    cct_readmux u_rd (
        .addr    (addr_i),
        .evt     (s_q.evt),
        .en      (s_q.en),
        .sh_clr  (s_q.sh_clr),
        .sh_stop (s_q.sh_stop),
        .mode    (s_q.mode),
        .width   (s_q.width),
        .pre     (s_q.pre),
        .cc      (s_q.cc),
        .rdata   (rdata_o)
    );

    always_comb begin
        s_d     = s_q;
        s_d.div = div_d;

        // register writes
        if (wr_i) begin
            if (addr_i == A_SHORTS) begin
                s_d.sh_clr  = wdata_i[CH_N-1:0];
                s_d.sh_stop = wdata_i[SH_STOP_LSB +: CH_N];
            end
            if (addr_i == A_INTSET) s_d.en = s_q.en | wdata_i[IEN_LSB +: CH_N];
            if (addr_i == A_INTCLR) s_d.en = s_q.en & ~wdata_i[IEN_LSB +: CH_N];
            if (addr_i == A_MODE)   s_d.mode  = mode_e'(wdata_i[0]);
            if (addr_i == A_WIDTH)  s_d.width = wdata_i[1:0];
            if (addr_i == A_PRE) begin
                s_d.pre = (wdata_i[PRE_W-1:0] > PRE_W'(PRE_MAX)) ?
                          PRE_W'(PRE_MAX) : wdata_i[PRE_W-1:0];
            end
            for (int i = 0; i < CH_N; i++) begin
                if (addr_i == A_CC + addr_t'(i)) s_d.cc[i] = wdata_i & wmask;
                if (addr_i == A_EVT + addr_t'(i) && wdata_i == '0) s_d.evt[i] = 1'b0;
            end
        end

        for (int i = 0; i < CH_N; i++) begin
            if (t_cap[i]) s_d.cc[i] = s_q.cnt;
        end

        // run control
        if (t_start && s_q.mode == MODE_TIMER) s_d.run = 1'b1;
        if (t_stop || t_shut)                  s_d.run = 1'b0;

        // counter step, clear task wins over a step
        if (t_clear)    s_d.cnt = '0;
        else if (adv)   s_d.cnt = do_clr ? '0 : nxt;

        // a match sets the flag even against a same-cycle flag clear
        s_d.evt = s_d.evt | hit;
        if (do_stop) s_d.run = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign irq_o = |(s_q.evt & s_q.en);

    // state views for the bound checker
    logic [CH_N-1:0]             evt_q, en_q;
    logic [DATA_W-1:0]           cnt_q;
    logic                        run_q;
    mode_e                       mode_q;
    logic [1:0]                  width_q;
    logic [CH_N-1:0][DATA_W-1:0] cc_q;

    assign evt_q   = s_q.evt;
    assign en_q    = s_q.en;
    assign cnt_q   = s_q.cnt;
    assign run_q   = s_q.run;
    assign mode_q  = s_q.mode;
    assign width_q = s_q.width;
    assign cc_q    = s_q.cc;
endmodule

// File: rtl/cct_checker.sv
module cct_checker
    import cct_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic                        irq_i,
    input  logic [CH_N-1:0]             evt_i,
    input  logic [CH_N-1:0]             en_i,
    input  logic [DATA_W-1:0]           cnt_i,
    input  logic                        run_i,
    input  mode_e                       mode_i,
    input  logic [1:0]                  width_i,
    input  logic [CH_N-1:0][DATA_W-1:0] cc_i
);
    logic one;
    assign one = (wdata_i == DATA_W'(1));

    for (genvar g = 0; g < CH_N; g++) begin : g_chk
        // R4: flag holds unless a zero is written to its event word
        assert_evt_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_i[g] && !(wr_i && addr_i == A_EVT + addr_t'(g) && wdata_i == '0))
            |=> evt_i[g]);

        // R10: stored compare value fits the width in force at the write
        assert_cc_modulo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && addr_i == A_CC + addr_t'(g))
            |=> ((cc_i[g] & ~$past(width_mask(width_i))) == '0));
    end

    // R3: in counter mode only a count or clear task moves the counter
    assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_COUNTER &&
         !(wr_i && one && (addr_i == A_COUNT || addr_i == A_CLEAR)))
        |=> $stable(cnt_i));

    // R3: the timer never starts without a start task
    assert_no_selfstart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !(wr_i && one && addr_i == A_START)) |=> !run_i);

    // R7: clearing every enable drops the interrupt
    assert_intclr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == A_INTCLR && wdata_i[IEN_LSB +: CH_N] == '1) |=> !irq_i);

    // R8: the interrupt rises only when a flag or an enable changed
    assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |-> ((evt_i != $past(evt_i)) || (en_i != $past(en_i))));
endmodule

bind cc_timer cct_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .irq_i   (irq_o),
    .evt_i   (evt_q),
    .en_i    (en_q),
    .cnt_i   (cnt_q),
    .run_i   (run_q),
    .mode_i  (mode_q),
    .width_i (width_q),
    .cc_i    (cc_q)
);

// File: tb/test_cc_timer.sv
`timescale 1ns/1ps
module test_cc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur = "R1";

    always #4 clk = ~clk;

    cc_timer i_cc_timer (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(b_wr), .addr_i(b_addr),
        .wdata_i(b_wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference model
    logic [31:0] m_cnt;
    logic [31:0] m_cc [4];
    bit          m_run, m_mode;
    int          m_w, m_pre, m_div;
    bit [3:0]    m_evt, m_en, m_sc, m_ss;

    function automatic longint modulus(int w);
        case (w)
            0: return 64'd65536;
            1: return 64'd256;
            2: return 64'd16777216;
            default: return 64'd4294967296;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_mode = 0; m_w = 0; m_pre = 0; m_div = 0;
            m_evt = 0; m_en = 0; m_sc = 0; m_ss = 0;
            for (int i = 0; i < 4; i++) m_cc[i] = 0;
        end else begin
            automatic bit      trig     = (b_wdata == 32'd1);
            automatic bit      is_timer = (m_mode == 1'b0);
            automatic bit      running  = is_timer && m_run;
            automatic int      period   = 1 << m_pre;
            automatic bit      tk       = running && ((m_div % period) == period - 1);
            automatic bit      clr      = b_wr && trig && b_addr == 6'd3;
            automatic bit      cnt_tk   = b_wr && trig && b_addr == 6'd2;
            automatic bit      step     = !clr && ((!is_timer && cnt_tk) || tk);
            automatic longint  nv       = (longint'(m_cnt) + 1) % modulus(m_w);
            automatic logic [31:0] old_cnt = m_cnt;
            automatic int      old_w    = m_w;
            automatic bit [3:0] hits    = 0;
            automatic bit      hclr = 0, hstop = 0;
            for (int i = 0; i < 4; i++) begin
                if (step && nv == longint'(m_cc[i])) begin
                    hits[i] = 1;
                    if (m_sc[i]) hclr = 1;
                    if (m_ss[i]) hstop = 1;
                end
            end
            if (b_wr) begin
                case (b_addr)
                    6'd32: begin m_sc = b_wdata[3:0]; m_ss = b_wdata[11:8]; end
                    6'd33: m_en = m_en | b_wdata[19:16];
                    6'd34: m_en = m_en & ~b_wdata[19:16];
                    6'd40: m_mode = b_wdata[0];
                    6'd41: m_w = int'(b_wdata[1:0]);
                    6'd42: m_pre = (b_wdata[3:0] > 9) ? 9 : int'(b_wdata[3:0]);
                    default: ;
                endcase
                if (b_addr >= 48 && b_addr <= 51)
                    m_cc[b_addr-48] = 32'(longint'(b_wdata) % modulus(old_w));
                if (b_addr >= 16 && b_addr <= 19 && b_wdata == 0)
                    m_evt[b_addr-16] = 0;
                if (b_addr >= 8 && b_addr <= 11 && trig)
                    m_cc[b_addr-8] = old_cnt;
                if (b_addr == 0 && trig && is_timer) m_run = 1;
                if ((b_addr == 1 || b_addr == 4) && trig) m_run = 0;
            end
            if (clr || (b_wr && trig && b_addr == 0 && is_timer)) m_div = 0;
            else if (running) m_div = m_div + 1;
            if (clr) m_cnt = 0;
            else if (step) m_cnt = hclr ? 32'd0 : 32'(nv);
            m_evt = m_evt | hits;
            if (hstop) m_run = 0;
        end
    end

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        logic [31:0] r = 0;
        case (a)
            6'd32: r = {20'b0, m_ss, 4'b0, m_sc};
            6'd33, 6'd34: r = {12'b0, m_en, 16'b0};
            6'd40: r = {31'b0, m_mode};
            6'd41: r = 32'(m_w);
            6'd42: r = 32'(m_pre);
            default: begin
                if (a >= 16 && a <= 19) r = {31'b0, m_evt[a-16]};
                if (a >= 48 && a <= 51) r = m_cc[a-48];
            end
        endcase
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({"R8 irq model ", cur}, {31'b0, irq}, {31'b0, |(m_evt & m_en)});
            chk({cur, " rdata model"}, rdata, exp_rd(b_addr));
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(posedge clk); #1;
        b_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string req);
        b_addr = a;
        @(negedge clk);
        chk(req, rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic irq_is(bit exp, string req);
        @(negedge clk);
        chk(req, {31'b0, irq}, {31'b0, exp});
        @(posedge clk); #1;
    endtask

    initial begin
        #1_520_000;
        errors++;
        $display("FAIL watchdog expired in phase %s actual hung expected done", cur);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cur = "R1";
        rd(6'd40, 0, "R1 mode"); rd(6'd48, 0, "R1 cc0"); rd(6'd33, 0, "R1 enable");
        rd(6'd32, 0, "R1 shorts"); rd(6'd16, 0, "R1 flag0"); rd(6'd42, 0, "R1 prescale");
        irq_is(0, "R1 irq");

        cur = "R2";
        wr(6'd40, 1); wr(6'd41, 1);
        repeat (3) wr(6'd2, 1);
        wr(6'd8, 1);
        rd(6'd48, 3, "R9 capture after three counts");
        wr(6'd49, 32'h1FF);
        rd(6'd49, 32'hFF, "R10 compare reduced to 8 bits");
        cur = "R4";
        repeat (252) wr(6'd2, 1);
        rd(6'd17, 1, "R4 flag1 at 255");
        rd(6'd16, 0, "R4 flag0 untouched");
        wr(6'd2, 1); wr(6'd10, 1);
        rd(6'd50, 0, "R2 8-bit wrap to zero");
        rd(6'd18, 1, "R4 flag2 on wrap match");
        wr(6'd17, 5);
        rd(6'd17, 1, "R4 nonzero write ignored");
        wr(6'd17, 0);
        rd(6'd17, 0, "R4 zero write clears");

        cur = "R8";
        wr(6'd18, 0); wr(6'd19, 0);
        wr(6'd49, 2); wr(6'd3, 1); wr(6'd33, 32'h0002_0000);
        irq_is(0, "R8 enabled but no flag");
        wr(6'd2, 1); wr(6'd2, 1);
        irq_is(1, "R8 flag and enable");
        rd(6'd34, 32'h0002_0000, "R7 clear word reads mask");
        rd(6'd33, 32'h0002_0000, "R7 set word reads mask");
        wr(6'd34, 32'h0002_0000);
        irq_is(0, "R8 enable removed");
        rd(6'd33, 0, "R7 mask cleared");
        rd(6'd17, 1, "R4 flag kept after enable clear");

        cur = "R11";
        wr(6'd3, 1); wr(6'd2, 2); wr(6'd2, 32'h101); wr(6'd8, 1);
        rd(6'd48, 0, "R11 count with value not 1");
        rd(6'd63, 0, "R11 unmapped word 63");
        rd(6'd5, 0, "R11 unmapped word 5");

        cur = "R3";
        wr(6'd40, 0); wr(6'd2, 1); wr(6'd8, 1);
        rd(6'd48, 0, "R3 count ignored in timer mode");
        wr(6'd40, 1); wr(6'd0, 1); wr(6'd40, 0); idle(5); wr(6'd8, 1);
        rd(6'd48, 0, "R3 start ignored in counter mode");
        wr(6'd42, 15);
        rd(6'd42, 9, "R3 prescale saturates");
        wr(6'd41, 0); wr(6'd42, 2); wr(6'd3, 1);
        wr(6'd0, 1); idle(39); wr(6'd1, 1); wr(6'd8, 1);
        rd(6'd48, 10, "R3 forty edges at prescale 2");
        idle(10); wr(6'd9, 1);
        rd(6'd49, 10, "R10 stop halts");

        cur = "R5";
        wr(6'd3, 1); wr(6'd42, 0); wr(6'd48, 5); wr(6'd16, 0); wr(6'd32, 1);
        wr(6'd0, 1); idle(21); wr(6'd1, 1); wr(6'd9, 1);
        rd(6'd49, 2, "R5 clear shortcut period five");
        rd(6'd16, 1, "R5 match flag set");

        cur = "R6";
        wr(6'd32, 32'h200); wr(6'd49, 7); wr(6'd3, 1);
        wr(6'd0, 1); idle(30); wr(6'd8, 1);
        rd(6'd48, 7, "R6 stop shortcut holds value");

        cur = "R10";
        wr(6'd32, 0); wr(6'd3, 1);
        wr(6'd0, 1); idle(9); wr(6'd4, 1); idle(10); wr(6'd8, 1);
        rd(6'd48, 10, "R10 shutdown halts");
        wr(6'd40, 1); wr(6'd41, 3); wr(6'd51, 32'hFFFF_FFFF);
        rd(6'd51, 32'hFFFF_FFFF, "R2 32-bit compare kept");
        wr(6'd41, 2); wr(6'd51, 32'h1234_5678);
        rd(6'd51, 32'h0034_5678, "R10 24-bit reduction");

        cur = "R2";
        wr(6'd41, 0); wr(6'd40, 0); wr(6'd3, 1);
        wr(6'd0, 1); idle(65538); wr(6'd1, 1); wr(6'd8, 1);
        rd(6'd48, 3, "R2 16-bit timer wrap");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule